// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo two's-complement serial audio stream into parallel samples. It runs directly on the incoming bit clock and samples the data line and the word clock on every rising edge. At the end of each word-clock half period it produces one 24-bit sample and a one-cycle strobe. A pulse on the left port marks a finished left word. A pulse on the right port marks a frame whose left and right words have both arrived.

Two format-select inputs pick the framing: right-justified MSB-first, right-justified LSB-first, left-justified or I2S. Two word-length inputs pick 16, 20 or 24 bits. Both pairs are sampled at word-clock transitions, so a host may change them at any time without breaking a word in flight. Words shorter than 24 bits are placed in the upper bits of the output with zeros below, so the sign bit always sits at bit 23.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmt_sel` = 2'b00 (right-justified, MSB first), the sample is the last N bits received before the word-clock transition, first of them being the MSB.
- R2: With `fmt_sel` = 2'b01 (right-justified, LSB first), the sample is the last N bits before the transition, first of them being the LSB.
- R3: With `fmt_sel` = 2'b10 (left-justified), the first N bits after the transition form the sample MSB first; every later bit of that half period has no effect on the output.
- R4: With `fmt_sel` = 2'b11 (I2S), the MSB is the bit taken on the second rising edge after the transition, and word clock low marks the left channel; in the other formats word clock high marks left.
- R5: `wlen_sel` = 2'b00 selects 16 bits, 2'b10 selects 20 bits, and 2'b01 or 2'b11 select 24 bits (bit 1 is the first select pin). A word of N bits appears in bits 23 down to 24-N of the output, with the lower bits zero.
- R6: Half periods of 24 and of 32 bit clocks (48 and 64 bit clocks per frame) are both decoded correctly.
- R7: The data outputs change only together with their strobe. `left_stb` pulses in the cycle after the edge that ends a left half. `right_stb` pulses after a right half only if a left word was delivered since the previous right strobe.
- R8: The half period in progress when reset is released is discarded. A right half that has no left half before it produces no strobe.
- R9: A change on `fmt_sel` or `wlen_sel` in the middle of a half period affects only words that start at a later word-clock transition.
- R10: While `rst` is high, both data outputs are zero and both strobes are low.
- R11: Each strobe is a single-cycle pulse, and the two strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; data and word clock sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wck | input | 1 | Word clock (channel select) |
| sdin | input | 1 | Serial data |
| fmt_sel | input | 2 | Framing select: 00 RJ MSB-first, 01 RJ LSB-first, 10 LJ, 11 I2S |
| wlen_sel | input | 2 | Word-length select: 00 16, 10 20, 01/11 24 bits |
| left_data | output | 24 | Last left sample, left-aligned |
| left_stb | output | 1 | One-cycle pulse on a new left sample |
| right_data | output | 24 | Last right sample, left-aligned |
| right_stb | output | 1 | One-cycle pulse when a full frame is complete |

## Verification
Every unused bit slot is filled with ones. A design that took the wrong window, such as a left-justified reader that keeps shifting past the LSB or an I2S reader that starts one bit early, shows it in the output sample. The LSB-first and 24-bit cases with no free slot catch bit-order and off-by-one errors at full width. Other directed runs begin a stream in the middle of a half period, and one begins with a lone right half. A design that decoded the partial half or strobed without a left word would produce extra strobes. One left half has its select inputs changed at its midpoint. A design that applied the change at once would decode that word in the wrong format.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int SW = 24;

    typedef enum logic [1:0] {
        FMT_RJ_MSB = 2'b00,
        FMT_RJ_LSB = 2'b01,
        FMT_LJ     = 2'b10,
        FMT_I2S    = 2'b11
    } srx_fmt_e;

    typedef struct packed {
        srx_fmt_e   fmt;
        logic [1:0] wl;
    } srx_cfg_t;

    // Word length from the select pair; bit 1 is the first pin.
    function automatic int word_bits(logic [1:0] wl);
        case (wl)
            2'b00:   return 16;
            2'b10:   return 20;
            default: return 24;
        endcase
    endfunction

    // Bits skipped after the word-clock transition before the MSB.
    function automatic int lead_skip(srx_fmt_e f);
        return (f == FMT_I2S) ? 1 : 0;
    endfunction

    // Pick the word out of the tail or head register and left-align it.
    function automatic logic [SW-1:0] align_word(srx_cfg_t c,
                                                 logic [SW-1:0] tail,
                                                 logic [SW-1:0] head);
        int            n;
        logic [SW-1:0] mask;
        logic [SW-1:0] raw;
        n    = word_bits(c.wl);
        mask = {SW{1'b1}} >> (SW - n);
        raw  = '0;
        case (c.fmt)
            FMT_RJ_MSB: raw = tail & mask;
            FMT_RJ_LSB: begin
                for (int i = 0; i < SW; i++) begin
                    if (i < n) raw[i] = tail[n-1-i];
                end
            end
            default:    raw = head & mask;
        endcase
        return raw << (SW - n);
    endfunction

endpackage

// File: rtl/srx_wclk_track.sv
module srx_wclk_track (
    input  logic clk,
    input  logic rst,
    input  logic wck,
    output logic edge_o,
    output logic prev_lvl_o,
    output logic seen_o
);
    logic live;

    assign edge_o = live && (wck != prev_lvl_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl_o <= 1'b0;
            live       <= 1'b0;
            seen_o     <= 1'b0;
        end else begin
            prev_lvl_o <= wck;
            live       <= 1'b1;
            if (edge_o) seen_o <= 1'b1;
        end
    end

    // R8: once the first complete boundary is seen it stays seen
    a_r8_seen_sticky: assert property (@(posedge clk) disable iff (rst)
        seen_o |=> seen_o);

endmodule

// File: rtl/srx_bit_capture.sv
module srx_bit_capture
    import srx_pkg::*;
#(
    parameter int W     = SW,
    parameter int CNT_W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sd,
    input  logic         edge_i,
    input  srx_cfg_t     cfg_now,
    input  srx_cfg_t     cfg_act,
    output logic [W-1:0] tail,
    output logic [W-1:0] head
);
    logic [CNT_W-1:0] idx;
    logic             in_win;
    int               n_act;
    int               off_act;

    always_comb begin
        n_act   = word_bits(cfg_act.wl);
        off_act = lead_skip(cfg_act.fmt);
        in_win  = (int'(idx) >= off_act) && (int'(idx) < off_act + n_act);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail <= '0;
            head <= '0;
            idx  <= '0;
        end else if (edge_i) begin
            tail <= {{(W-1){1'b0}}, sd};
            head <= (lead_skip(cfg_now.fmt) == 0) ? {{(W-1){1'b0}}, sd} : '0;
            idx  <= CNT_W'(1);
        end else begin
            tail <= {tail[W-2:0], sd};
            if (in_win) head <= {head[W-2:0], sd};
            if (idx != '1) idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/srx_word_out.sv
module srx_word_out
    import srx_pkg::*;
#(
    parameter int W = SW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         edge_i,
    input  logic         seen_i,
    input  logic         prev_lvl,
    input  srx_cfg_t     cfg_act,
    input  logic [W-1:0] tail,
    input  logic [W-1:0] head,
    output logic [W-1:0] left_data,
    output logic         left_stb,
    output logic [W-1:0] right_data,
    output logic         right_stb
);
    logic         is_left;
    logic         got_left;
    logic [W-1:0] word;

    assign is_left = (cfg_act.fmt == FMT_I2S) ? !prev_lvl : prev_lvl;
    assign word    = align_word(cfg_act, tail, head);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_data  <= '0;
            right_data <= '0;
            left_stb   <= 1'b0;
            right_stb  <= 1'b0;
            got_left   <= 1'b0;
        end else begin
            left_stb  <= 1'b0;
            right_stb <= 1'b0;
            if (edge_i && seen_i) begin
                if (is_left) begin
                    left_data <= word;
                    left_stb  <= 1'b1;
                    got_left  <= 1'b1;
                end else if (got_left) begin
                    right_data <= word;
                    right_stb  <= 1'b1;
                    got_left   <= 1'b0;
                end
            end
        end
    end

    a_r11_excl: assert property (@(posedge clk) disable iff (rst)
        !(left_stb && right_stb));
    a_r11_pulse_l: assert property (@(posedge clk) disable iff (rst)
        left_stb |=> !left_stb);
    a_r7_hold_l: assert property (@(posedge clk) disable iff (rst)
        !left_stb |-> $stable(left_data));
    a_r7_hold_r: assert property (@(posedge clk) disable iff (rst)
        !right_stb |-> $stable(right_data));
    a_r7_right_on_edge: assert property (@(posedge clk) disable iff (rst)
        right_stb |-> $past(edge_i && seen_i));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import srx_pkg::*;
#(
    parameter int W     = SW,
    parameter int CNT_W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wck,
    input  logic         sdin,
    input  logic [1:0]   fmt_sel,
    input  logic [1:0]   wlen_sel,
    output logic [W-1:0] left_data,
    output logic         left_stb,
    output logic [W-1:0] right_data,
    output logic         right_stb
);
    srx_cfg_t     cfg_now;
    srx_cfg_t     cfg_act;
    logic         wedge;
    logic         prev_lvl;
    logic         seen;
    logic [W-1:0] tail;
    logic [W-1:0] head;

    assign cfg_now = '{fmt: srx_fmt_e'(fmt_sel), wl: wlen_sel};

    // Framing in force for the half period that is being received.
    always_ff @(posedge clk) begin
        if (rst)        cfg_act <= '{fmt: FMT_RJ_MSB, wl: 2'b00};
        else if (wedge) cfg_act <= cfg_now;
    end

    srx_wclk_track u_track (
        .clk        (clk),
        .rst        (rst),
        .wck        (wck),
        .edge_o     (wedge),
        .prev_lvl_o (prev_lvl),
        .seen_o     (seen)
    );

    srx_bit_capture #(.W(W), .CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .sd      (sdin),
        .edge_i  (wedge),
        .cfg_now (cfg_now),
        .cfg_act (cfg_act),
        .tail    (tail),
        .head    (head)
    );

    srx_word_out #(.W(W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .edge_i     (wedge),
        .seen_i     (seen),
        .prev_lvl   (prev_lvl),
        .cfg_act    (cfg_act),
        .tail       (tail),
        .head       (head),
        .left_data  (left_data),
        .left_stb   (left_stb),
        .right_data (right_data),
        .right_stb  (right_stb)
    );

    // R9: the latched framing only moves at a word-clock transition
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !wedge |=> $stable(cfg_act));

endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

    localparam int CLK_NS = 10;
    localparam int NV     = 11;
    // {fmt[1:0], wl[1:0], 64-clock frame, left[23:0], right[23:0]}
    localparam logic [52:0] VEC [NV] = '{
        {2'b00, 2'b00, 1'b0, 24'h008001, 24'h007FFE},
        {2'b01, 2'b00, 1'b1, 24'h001234, 24'h00C3A5},
        {2'b10, 2'b10, 1'b0, 24'h080F0F, 24'h07A5A5},
        {2'b11, 2'b01, 1'b1, 24'h800001, 24'h123456},
        {2'b11, 2'b00, 1'b0, 24'h00FFFF, 24'h000001},
        {2'b00, 2'b11, 1'b1, 24'hA5A5A5, 24'h5A5A5A},
        {2'b01, 2'b11, 1'b0, 24'h000001, 24'hFFFFFE},
        {2'b10, 2'b11, 1'b1, 24'hC00003, 24'h3FFFFC},
        {2'b00, 2'b10, 1'b0, 24'h0FEDCB, 24'h001234},
        {2'b11, 2'b10, 1'b1, 24'h087654, 24'h0789AB},
        {2'b10, 2'b00, 1'b1, 24'h00BEEF, 24'h008421}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wck = 1'b1;
    logic        sdin = 1'b1;
    logic [1:0]  fmt_sel = 2'b00;
    logic [1:0]  wlen_sel = 2'b00;
    logic [23:0] left_data, right_data;
    logic        left_stb, right_stb;

    always #(CLK_NS/2) clk = ~clk;

    serial_audio_rx u_dut (
        .clk        (clk),
        .rst        (rst),
        .wck        (wck),
        .sdin       (sdin),
        .fmt_sel    (fmt_sel),
        .wlen_sel   (wlen_sel),
        .left_data  (left_data),
        .left_stb   (left_stb),
        .right_data (right_data),
        .right_stb  (right_stb)
    );

    int          nchk = 0, nfail = 0;
    logic        cur = 1'b1;
    logic [23:0] exp_l [64], exp_r [64], cap_l [64], cap_r [64];
    string       tag_l [64], tag_r [64];
    int          pl = 0, pr = 0, nl = 0, nr = 0, sl0 = 0, sr0 = 0;
    int          both_cnt = 0, dbl_cnt = 0;
    logic        plv = 1'b0, prv = 1'b0;

    // Pulse monitor: records strobed words, sampled away from the rising edge.
    always @(negedge clk) begin
        if (left_stb && right_stb) both_cnt++;
        if ((left_stb && plv) || (right_stb && prv)) dbl_cnt++;
        plv = left_stb;
        prv = right_stb;
        if (left_stb) begin
            if (nl < 64) cap_l[nl] = left_data;
            nl++;
        end
        if (right_stb) begin
            if (nr < 64) cap_r[nr] = right_data;
            nr++;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [23:0] act, input logic [23:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic int bits_of(input logic [1:0] w);
        if (w == 2'b00) return 16;
        if (w == 2'b10) return 20;
        return 24;
    endfunction

    function automatic logic [23:0] expect_word(input logic [23:0] v, input int n);
        logic [23:0] m;
        m = {24{1'b1}} >> (24 - n);
        return (v & m) << (24 - n);
    endfunction

    // Serial bit at slot p of a half period; free slots carry ones.
    function automatic logic line_bit(input logic [1:0] f, input int n,
                                      input int hb, input int p,
                                      input logic [23:0] v);
        case (f)
            2'b00:   return (p >= hb - n) ? v[hb-1-p] : 1'b1;
            2'b01:   return (p >= hb - n) ? v[p-(hb-n)] : 1'b1;
            2'b10:   return (p < n) ? v[n-1-p] : 1'b1;
            default: return (p >= 1 && p <= n) ? v[n-p] : 1'b1;
        endcase
    endfunction

    task automatic send_half(input logic lvl, input logic [23:0] v,
                             input logic [1:0] f, input logic [1:0] w,
                             input int hb, input logic [1:0] mf,
                             input logic [1:0] mw);
        int n;
        n = bits_of(w);
        for (int p = 0; p < hb; p++) begin
            @(negedge clk);
            if (p == 0) begin
                wck      = lvl;
                fmt_sel  = f;
                wlen_sel = w;
            end
            if (p == hb / 2) begin
                fmt_sel  = mf;
                wlen_sel = mw;
            end
            sdin = line_bit(f, n, hb, p, v);
        end
        cur = lvl;
    endtask

    task automatic push(input logic [23:0] l, input logic [23:0] r,
                        input int n, input string tag);
        exp_l[pl] = expect_word(l, n); tag_l[pl] = tag; pl++;
        exp_r[pr] = expect_word(r, n); tag_r[pr] = tag; pr++;
    endtask

    task automatic frame(input logic [1:0] f, input logic [1:0] w, input int hb,
                         input logic [23:0] l, input logic [23:0] r,
                         input string tag);
        logic first;
        first = (f == 2'b11) ? 1'b0 : 1'b1;
        if (cur == first) send_half(!first, 24'hFFFFFF, f, w, 24, f, w);
        push(l, r, bits_of(w), tag);
        send_half(first, l, f, w, hb, f, w);
        send_half(!first, r, f, w, hb, f, w);
    endtask

    task automatic open_section();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(left_data == 24'h0 && right_data == 24'h0, "R10 data in reset",
            left_data | right_data, 24'h0);
        chk(!left_stb && !right_stb, "R10 strobes in reset",
            {22'h0, left_stb, right_stb}, 24'h0);
        wck  = 1'b1;
        cur  = 1'b1;
        sdin = 1'b1;
        rst  = 1'b0;
        repeat (5) @(negedge clk);
        sl0 = pl;
        sr0 = pr;
    endtask

    task automatic close_section(input string tag);
        send_half(!cur, 24'hFFFFFF, fmt_sel, wlen_sel, 24, fmt_sel, wlen_sel);
        repeat (3) @(negedge clk);
        chk(nl == pl, {tag, " R7 left strobe count"}, 24'(nl), 24'(pl));
        chk(nr == pr, {tag, " R7 right strobe count"}, 24'(nr), 24'(pr));
        for (int i = sl0; i < pl && i < nl; i++)
            chk(cap_l[i] == exp_l[i], {tag_l[i], " left"}, cap_l[i], exp_l[i]);
        for (int i = sr0; i < pr && i < nr; i++)
            chk(cap_r[i] == exp_r[i], {tag_r[i], " right"}, cap_r[i], exp_r[i]);
    endtask

    initial begin
        // Vector table: every format, word length and frame size.
        open_section();
        for (int i = 0; i < NV; i++) begin
            string t;
            case (VEC[i][52:51])
                2'b00:   t = "R1 R5 R6 rj-msb";
                2'b01:   t = "R2 R5 R6 rj-lsb";
                2'b10:   t = "R3 R5 R6 lj";
                default: t = "R4 R5 R6 i2s";
            endcase
            frame(VEC[i][52:51], VEC[i][50:49], VEC[i][48] ? 32 : 24,
                  VEC[i][47:24], VEC[i][23:0], t);
        end
        close_section("table");

        // R8: partial half after reset and a lone right half give no strobe.
        open_section();
        send_half(1'b0, 24'h00ABCD, 2'b00, 2'b00, 24, 2'b00, 2'b00);
        frame(2'b00, 2'b00, 24, 24'h001357, 24'h002468, "R8 after lone right");
        close_section("R8");

        // R9: select inputs changed mid left half apply from the next edge.
        open_section();
        send_half(1'b0, 24'hFFFFFF, 2'b00, 2'b00, 24, 2'b00, 2'b00);
        exp_l[pl] = expect_word(24'h00F00D, 16); tag_l[pl] = "R9 old format kept"; pl++;
        exp_r[pr] = expect_word(24'h5C3A11, 24); tag_r[pr] = "R9 new format used"; pr++;
        send_half(1'b1, 24'h00F00D, 2'b00, 2'b00, 32, 2'b10, 2'b11);
        send_half(1'b0, 24'h5C3A11, 2'b10, 2'b11, 32, 2'b10, 2'b11);
        close_section("R9");

        // R11: strobe shape over the whole run.
        chk(both_cnt == 0, "R11 strobes overlap", 24'(both_cnt), 24'h0);
        chk(dbl_cnt == 0, "R11 strobe longer than one cycle", 24'(dbl_cnt), 24'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
        $finish;
    end

endmodule